// File: doc/BRIEF.md
# Keyed Configuration Write Guard

This block sits beside a bank of configuration registers and decides, for each bus write, whether that write may land. It owns two registers of its own: a mode register that holds a single protection-enable bit, and a status register that logs the most recent blocked write. The enable bit changes only when the write to the mode register also carries a fixed 24-bit unlock key in its upper bits. A write that carries any other key leaves the enable bit alone.

While protection is on, any write to one of a parameterised list of guarded offsets is refused. The block lowers `wr_allow` in the same cycle, raises a violation flag and records the offending address. Software reads the status register to collect the log, and that read clears it. The guarded registers themselves live outside this block and are gated by `wr_allow`.

Top module: `cfg_write_guard`

## Requirements
- R1: After reset the mode register and the status register both read as 0x00000000, and every write is allowed.
- R2: A write to offset 0xE4 whose bits 31:8 equal 0x535343 loads the enable bit from write-data bit 0. The new value applies to writes from the next cycle on.
- R3: A write to offset 0xE4 whose bits 31:8 differ from 0x535343 leaves the enable bit unchanged.
- R4: A read of offset 0xE4 returns the enable bit in bit 0 and zero in every other bit, including the key field in bits 31:8.
- R5: While the enable bit is 1, a write to offset 0x04, 0x10, 0x14, 0x18 or 0x1C drives `wr_allow` low in the cycle of the write.
- R6: A write to any other offset is always allowed, and every write is allowed while the enable bit is 0. `wr_allow` is never high without `bus_wr`.
- R7: A refused write sets the violation flag (status bit 0) and loads the low 16 bits of the write address into status bits 23:8.
- R8: A read of offset 0xE8 returns the status value and clears both the flag and the source field, so the next read returns 0.
- R9: When several writes are refused before a status read, the source field holds the address of the most recent one.
- R10: Read data is registered and appears one cycle after `bus_rd`. A read of an offset the block does not own returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| wr_allow | output | 1 | High when the current write may update its target |

## Verification
`wr_allow` is combinational, so the bench checks it one time unit after it drives a write at the falling edge, before the rising edge that would commit the write. Changes to the enable bit and the violation log take effect at the rising edge of the write. Read data is due one register stage after the `bus_rd` edge, so every read task samples `bus_rdata` shortly after that rising edge. The effect of each enable change is confirmed on the next write, never within the same one.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
   localparam int unsigned ADDR_W    = 16;
   localparam int unsigned DATA_W    = 32;
   localparam int unsigned KEY_W     = 24;
   localparam int unsigned KEY_LSB   = 8;
   localparam int unsigned SRC_W     = 16;
   localparam int unsigned SRC_LSB   = 8;
   localparam logic [ADDR_W-1:0] MODE_OFF = 16'h00E4;
   localparam logic [ADDR_W-1:0] STAT_OFF = 16'h00E8;
   localparam logic [KEY_W-1:0]  UNLOCK_KEY = 24'h535343;
   localparam int unsigned NUM_GUARDED = 5;
   localparam logic [NUM_GUARDED*ADDR_W-1:0] GUARDED_LIST =
      {16'h001C, 16'h0018, 16'h0014, 16'h0010, 16'h0004};
endpackage

// File: rtl/cwg_match.sv
module cwg_match #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned NUM    = 5,
   parameter logic [NUM*ADDR_W-1:0] LIST = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   logic [NUM-1:0] eq;

   if (NUM == 0) begin : g_bad_num
      $error("cwg_match: NUM must be at least 1");
   end

   for (genvar i = 0; i < NUM; i++) begin : g_cmp
      assign eq[i] = (addr == LIST[i*ADDR_W +: ADDR_W]);
   end

   assign hit = |eq;
endmodule

// File: rtl/cwg_mode_reg.sv
module cwg_mode_reg #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned KEY_W   = 24,
   parameter int unsigned KEY_LSB = 8,
   parameter logic [KEY_W-1:0] KEY = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wdata,
   output logic              prot_en
);
   localparam int unsigned KEY_MSB = KEY_LSB + KEY_W - 1;

   if (KEY_MSB >= DATA_W || KEY_LSB == 0) begin : g_bad_key
      $error("cwg_mode_reg: key field must fit above bit 0 of the data word");
   end

   logic key_ok;
   assign key_ok = (wdata[KEY_MSB:KEY_LSB] == KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prot_en <= 1'b0;
      else if (wr_sel && key_ok)
         prot_en <= wdata[0];
   end

   // R3
   bad_key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && !key_ok) |=> $stable(prot_en));

   // R2
   good_key_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && key_ok) |=> (prot_en == $past(wdata[0])));
endmodule

// File: rtl/cwg_viol_log.sv
module cwg_viol_log #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned SRC_W       = 16,
   parameter bit          KEEP_FIRST  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blocked,
   input  logic [ADDR_W-1:0] addr,
   input  logic              clr,
   output logic              flag,
   output logic [SRC_W-1:0]  src
);
   logic [SRC_W-1:0] addr_fit;
   logic             load;

   if (ADDR_W >= SRC_W) begin : g_trunc
      assign addr_fit = addr[SRC_W-1:0];
   end else begin : g_pad
      assign addr_fit = {{(SRC_W-ADDR_W){1'b0}}, addr};
   end

   if (KEEP_FIRST) begin : g_first
      assign load = blocked && !flag;
   end else begin : g_last
      assign load = blocked;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         src  <= '0;
      end else if (blocked) begin
         flag <= 1'b1;
         if (load) src <= addr_fit;
      end else if (clr) begin
         flag <= 1'b0;
         src  <= '0;
      end
   end

   // R7
   blocked_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |=> flag);

   // R8
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !blocked) |=> (!flag && src == '0));
endmodule

// File: rtl/cfg_write_guard.sv
module cfg_write_guard
   import cwg_pkg::*;
#(
   parameter int unsigned A_W  = ADDR_W,
   parameter int unsigned D_W  = DATA_W,
   parameter int unsigned NG   = NUM_GUARDED,
   parameter logic [NG*A_W-1:0] GLIST = GUARDED_LIST,
   parameter logic [A_W-1:0] MODE_A = MODE_OFF,
   parameter logic [A_W-1:0] STAT_A = STAT_OFF,
   parameter logic [KEY_W-1:0] KEYV = UNLOCK_KEY,
   parameter bit KEEP_FIRST = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [A_W-1:0] bus_addr,
   input  logic [D_W-1:0] bus_wdata,
   input  logic           bus_wr,
   input  logic           bus_rd,
   output logic [D_W-1:0] bus_rdata,
   output logic           wr_allow
);
   localparam int unsigned SRC_MSB = SRC_LSB + SRC_W - 1;

   if (SRC_MSB >= D_W) begin : g_bad_src
      $error("cfg_write_guard: source field exceeds data width");
   end

   logic             hit;
   logic             prot_en;
   logic             blocked;
   logic             flag;
   logic [SRC_W-1:0] src;
   logic             mode_sel;
   logic             stat_rd;
   logic [D_W-1:0]   rd_mux;

   cwg_match #(.ADDR_W(A_W), .NUM(NG), .LIST(GLIST)) u_match (
      .addr (bus_addr),
      .hit  (hit)
   );

   assign mode_sel = bus_wr && (bus_addr == MODE_A);

   cwg_mode_reg #(.DATA_W(D_W), .KEY_W(KEY_W), .KEY_LSB(KEY_LSB), .KEY(KEYV)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_sel  (mode_sel),
      .wdata   (bus_wdata),
      .prot_en (prot_en)
   );

   assign blocked  = bus_wr && prot_en && hit;
   assign wr_allow = bus_wr && !blocked;
   assign stat_rd  = bus_rd && (bus_addr == STAT_A);

   cwg_viol_log #(.ADDR_W(A_W), .SRC_W(SRC_W), .KEEP_FIRST(KEEP_FIRST)) u_log (
      .clk     (clk),
      .rst_n   (rst_n),
      .blocked (blocked),
      .addr    (bus_addr),
      .clr     (stat_rd),
      .flag    (flag),
      .src     (src)
   );

   always_comb begin
      rd_mux = '0;
      if (bus_addr == MODE_A) begin
         rd_mux[0] = prot_en;
      end else if (bus_addr == STAT_A) begin
         rd_mux[0] = flag;
         rd_mux[SRC_MSB:SRC_LSB] = src;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_rd)
         bus_rdata <= rd_mux;
      else
         bus_rdata <= '0;
   end

   // R6
   allow_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_allow |-> bus_wr);

   // R10
   idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/cfg_write_guard_test.sv
module cfg_write_guard_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        wr_allow;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   cfg_write_guard uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .wr_allow  (wr_allow)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic do_write(string req, logic [15:0] a, logic [31:0] d, logic exp_allow);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      #1;
      check(req, {31'b0, wr_allow}, {31'b0, exp_allow});
      @(posedge clk);
      #1;
      bus_wr = 1'b0;
   endtask

   task automatic do_read(string req, logic [15:0] a, logic [31:0] exp);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
      @(posedge clk);
      #1;
      bus_rd = 1'b0;
      check(req, bus_rdata, exp);
   endtask

   task automatic t_reset();
      do_read("R1 mode after reset", 16'h00E4, 32'h0);
      do_read("R1 status after reset", 16'h00E8, 32'h0);
      do_write("R1 guarded write allowed after reset", 16'h0010, 32'h1234, 1'b1);
   endtask

   task automatic t_wrong_key();
      do_write("R3 mode write, wrong key", 16'h00E4, 32'h53534401, 1'b1);
      do_read("R3 enable unchanged", 16'h00E4, 32'h0);
      do_write("R6 write allowed while disabled", 16'h0014, 32'hFFFF, 1'b1);
      do_read("R6 no log while disabled", 16'h00E8, 32'h0);
   endtask

   task automatic t_enable();
      do_write("R2 mode write, good key", 16'h00E4, 32'h53534301, 1'b1);
      do_read("R4 mode readback hides key", 16'h00E4, 32'h00000001);
   endtask

   task automatic t_block_all();
      logic [15:0] offs [5] = '{16'h0004, 16'h0010, 16'h0014, 16'h0018, 16'h001C};
      for (int i = 0; i < 5; i++)
         do_write("R5 guarded write refused", offs[i], 32'hA5A5, 1'b0);
      do_write("R6 unguarded write allowed while enabled", 16'h0008, 32'h1, 1'b1);
      do_write("R6 unguarded write allowed while enabled", 16'h0024, 32'h1, 1'b1);
      do_read("R9 newest source kept", 16'h00E8, 32'h00001C01);
      do_read("R8 status cleared by read", 16'h00E8, 32'h0);
   endtask

   task automatic t_single();
      do_write("R5 single refusal", 16'h0004, 32'h0, 1'b0);
      do_read("R7 flag and source", 16'h00E8, 32'h00000401);
      do_read("R8 second read zero", 16'h00E8, 32'h0);
   endtask

   task automatic t_disable();
      do_write("R3 disable attempt, no key", 16'h00E4, 32'h00000000, 1'b1);
      do_write("R3 still enabled, write refused", 16'h0018, 32'h0, 1'b0);
      do_write("R2 disable with key", 16'h00E4, 32'h53534300, 1'b1);
      do_read("R4 mode reads zero", 16'h00E4, 32'h0);
      do_write("R6 guarded write allowed again", 16'h0018, 32'h0, 1'b1);
      do_read("R7 earlier refusal logged", 16'h00E8, 32'h00001801);
      do_read("R10 unowned offset reads zero", 16'h0020, 32'h0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            #1 rst_n = 1'b1;
            t_reset();
            t_wrong_key();
            t_enable();
            t_block_all();
            t_single();
            t_disable();
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule